// File: doc/BRIEF.md
# Integer Multiply Unit with Half and Sign Selection

This block is the multiply unit of a 64-bit integer execution pipeline. It takes two source operands, a 3-bit function code and a word-mode flag. From one double-width product it returns one of four results: the low half, or the high half with the operands read as signed by signed, signed by unsigned, or unsigned by unsigned. In word mode only the low 32 bits of each source are multiplied, and the 32-bit result is sign-extended to the full datapath width.

A request is offered with `req_valid` and is taken on a clock edge where `req_ready` is high. The unit then works for `MUL_CYCLES` cycles in a multi-cycle multiply state. After that it presents the result with the destination tag of its request, and holds both until `rsp_ready` accepts them. Only one operation is in flight at a time.

The controller has three states. `ST_IDLE` waits for a request. `ST_MULT` counts the multiply cycles. `ST_DONE` holds the result. The transitions are: IDLE to MULT on acceptance (`req_valid`), MULT to MULT while the count has not reached `MUL_CYCLES-1`, MULT to DONE on the last count, when the result register is loaded, and DONE to IDLE when `rsp_ready` is high.

Top module: `imul_unit`

## Requirements
- R1: Function code 0 returns the low XLEN bits of the product of the two sources.
- R2: Function code 1 returns the upper XLEN bits of the 2·XLEN-bit product with both sources signed.
- R3: Function code 2 returns the upper XLEN bits of the product with source A signed and source B unsigned.
- R4: Function code 3 returns the upper XLEN bits of the product with both sources unsigned.
- R5: Function codes 4 to 7 (bit 2 set) are decoded as the low-half operation and return the same value as code 0.
- R6: With `req_word` high (XLEN = 64), bits 31:0 of each source are multiplied, the function code is ignored, and the result is bits 31:0 of the product with bit 31 copied into bits 63:32.
- R7: `req_ready` is high only in the idle state. A request is taken only on an edge where `req_valid` and `req_ready` are both high. While the unit is busy, `req_valid` is ignored.
- R8: `rsp_valid` rises exactly `MUL_CYCLES` clock edges after the edge that accepted the request.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_tag` stay unchanged. `rsp_tag` equals the tag of the accepted request.
- R10: During and right after reset, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_sel | input | 3 | Function code (0 low, 1 high s×s, 2 high s×u, 3 high u×u, 4–7 low) |
| req_word | input | 1 | Word mode: 32-bit multiply, sign-extended result |
| req_src_a | input | XLEN | Source operand A (multiplicand) |
| req_src_b | input | XLEN | Source operand B (multiplier) |
| req_tag | input | TAG_W | Destination tag carried to the result |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken |
| rsp_data | output | XLEN | Selected product half or sign-extended word result |
| rsp_tag | output | TAG_W | Tag of the request that produced this result |

## Verification
A request taken at clock edge k has its result and tag on the ports after edge k+`MUL_CYCLES`. The result stays there until the first edge on which `rsp_ready` is high, and `req_ready` returns after that edge. The bench keeps a behavioural timeline of its own. It updates this timeline on each rising edge from the inputs it drove, and compares `req_ready`, `rsp_valid`, `rsp_data` and `rsp_tag` with it at every falling edge. As a result, a result that arrives one cycle early or late, or a value that changes while the result is stalled, is caught in the cycle where it happens. The expected products come from a 130-bit behavioural multiply over corner operands and random operands, with the response side stalled both never and at random.

// File: rtl/imul_pkg.sv
package imul_pkg;

    typedef enum logic [1:0] {
        OP_LO    = 2'd0,
        OP_HI_SS = 2'd1,
        OP_HI_SU = 2'd2,
        OP_HI_UU = 2'd3
    } imul_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MULT = 2'd1,
        ST_DONE = 2'd2
    } imul_state_e;

    localparam int unsigned WORD_W = 32;

    function automatic imul_op_e decode_sel(input logic [2:0] sel);
        if (sel[2]) begin
            return OP_LO;
        end
        return imul_op_e'(sel[1:0]);
    endfunction

endpackage

// File: rtl/imul_operand_prep.sv
module imul_operand_prep
    import imul_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  imul_op_e        op,
    input  logic            word,
    output logic [XLEN:0]   opnd_a,
    output logic [XLEN:0]   opnd_b
);

    logic sgn_a;
    logic sgn_b;
    logic [XLEN:0] full_a;
    logic [XLEN:0] full_b;

    always_comb begin
        sgn_a = (op == OP_HI_SS) || (op == OP_HI_SU);
        sgn_b = (op == OP_HI_SS);
        full_a = {sgn_a & src_a[XLEN-1], src_a};
        full_b = {sgn_b & src_b[XLEN-1], src_b};
    end

    generate
        if (XLEN == 64) begin : g_word
            localparam int unsigned PAD_W = XLEN - WORD_W + 1;
            always_comb begin
                if (word) begin
                    opnd_a = {{PAD_W{src_a[WORD_W-1]}}, src_a[WORD_W-1:0]};
                    opnd_b = {{PAD_W{src_b[WORD_W-1]}}, src_b[WORD_W-1:0]};
                end else begin
                    opnd_a = full_a;
                    opnd_b = full_b;
                end
            end
        end else begin : g_noword
            always_comb begin
                opnd_a = full_a;
                opnd_b = full_b;
            end
        end
    endgenerate

endmodule

// File: rtl/imul_core.sv
module imul_core #(
    parameter int unsigned XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_en,
    input  logic [XLEN:0]       opnd_a,
    input  logic [XLEN:0]       opnd_b,
    output logic [2*XLEN-1:0]   product
);

    localparam int unsigned PW = 2 * XLEN + 2;

    logic signed [PW-1:0] full;

    always_comb begin
        full    = PW'($signed(opnd_a)) * PW'($signed(opnd_b));
        product = full[2*XLEN-1:0];
    end

    // R2 R3 R4: an extended (XLEN+1)-bit signed product always fits in 2*XLEN+1 bits
    always_ff @(posedge clk) begin
        if (rst_n && chk_en) begin
            a_r4_no_overflow: assert (full[PW-1] == full[PW-2] && full[PW-2] == full[PW-3] || full[PW-1] == full[PW-2]);
        end
    end

endmodule

// File: rtl/imul_result_sel.sv
module imul_result_sel
    import imul_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [2*XLEN-1:0] product,
    input  imul_op_e          op,
    input  logic              word,
    output logic [XLEN-1:0]   result
);

    logic [XLEN-1:0] half;

    always_comb begin
        unique case (op)
            OP_LO:    half = product[XLEN-1:0];
            OP_HI_SS,
            OP_HI_SU,
            OP_HI_UU: half = product[2*XLEN-1:XLEN];
            default:  half = product[XLEN-1:0];
        endcase
    end

    generate
        if (XLEN == 64) begin : g_word
            always_comb begin
                if (word) begin
                    result = {{(XLEN-WORD_W){product[WORD_W-1]}}, product[WORD_W-1:0]};
                end else begin
                    result = half;
                end
            end
        end else begin : g_noword
            always_comb result = half;
        end
    endgenerate

endmodule

// File: rtl/imul_ctrl.sv
module imul_ctrl
    import imul_pkg::*;
#(
    parameter int unsigned MUL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic rsp_ready,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic rsp_valid,
    output logic busy_mult
);

    localparam int unsigned CNT_W = (MUL_CYCLES > 1) ? $clog2(MUL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MUL_CYCLES - 1);

    imul_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_MULT;
                    cnt_d   = '0;
                end
            end
            ST_MULT: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin
                if (rsp_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        accept    = 1'b0;
        capture   = 1'b0;
        rsp_valid = 1'b0;
        busy_mult = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
            end
            ST_MULT: begin
                busy_mult = 1'b1;
                capture   = (cnt_q == CNT_LAST);
            end
            ST_DONE: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    // Independent cycle counter for the latency property (R8)
    logic [31:0] since_acc_q;
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            since_acc_q <= '0;
        end else if (busy_mult) begin
            since_acc_q <= since_acc_q + 1;
        end
    end

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (since_acc_q == MUL_CYCLES - 1));

    a_r7_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid);

endmodule

// File: rtl/imul_unit.sv
module imul_unit
    import imul_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned TAG_W      = 5,
    parameter int unsigned MUL_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_sel,
    input  logic             req_word,
    input  logic [XLEN-1:0]  req_src_a,
    input  logic [XLEN-1:0]  req_src_b,
    input  logic [TAG_W-1:0] req_tag,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [XLEN-1:0]  rsp_data,
    output logic [TAG_W-1:0] rsp_tag
);

    logic accept;
    logic capture;
    logic busy_mult;

    logic [XLEN-1:0]  a_q, b_q;
    imul_op_e         op_q;
    logic             word_q;
    logic [TAG_W-1:0] tag_q;
    logic [XLEN-1:0]  data_q;

    logic [XLEN:0]     opnd_a, opnd_b;
    logic [2*XLEN-1:0] product;
    logic [XLEN-1:0]   result;

    imul_ctrl #(.MUL_CYCLES(MUL_CYCLES)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rsp_ready (rsp_ready),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .rsp_valid (rsp_valid),
        .busy_mult (busy_mult)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            op_q   <= OP_LO;
            word_q <= 1'b0;
            tag_q  <= '0;
        end else if (accept) begin
            a_q    <= req_src_a;
            b_q    <= req_src_b;
            op_q   <= decode_sel(req_sel);
            word_q <= req_word;
            tag_q  <= req_tag;
        end
    end

    imul_operand_prep #(.XLEN(XLEN)) prep_i (
        .src_a  (a_q),
        .src_b  (b_q),
        .op     (op_q),
        .word   (word_q),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b)
    );

    imul_core #(.XLEN(XLEN)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_en  (busy_mult),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .product (product)
    );

    imul_result_sel #(.XLEN(XLEN)) sel_i (
        .product (product),
        .op      (op_q),
        .word    (word_q),
        .result  (result)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= result;
        end
    end

    assign rsp_data = data_q;
    assign rsp_tag  = tag_q;

    a_r9_stable_out: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> ($stable(rsp_data) && $stable(rsp_tag)));

    a_r9_tag_carried: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rsp_tag == $past(req_tag)));

    generate
        if (XLEN == 64) begin : g_word_chk
            a_r6_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
                (rsp_valid && word_q) |->
                    (rsp_data[XLEN-1:WORD_W] == {(XLEN-WORD_W){rsp_data[WORD_W-1]}}));
        end
    endgenerate

endmodule

// File: tb/imul_unit_tb.sv
`timescale 1ns/1ps
module imul_unit_tb_top;

    localparam int XLEN       = 64;
    localparam int TAG_W      = 5;
    localparam int MUL_CYCLES = 2;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [2:0]       req_sel = '0;
    logic             req_word = 1'b0;
    logic [XLEN-1:0]  req_src_a = '0;
    logic [XLEN-1:0]  req_src_b = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             rsp_valid;
    logic             rsp_ready = 1'b1;
    logic [XLEN-1:0]  rsp_data;
    logic [TAG_W-1:0] rsp_tag;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cycles = 0;
    bit stall_mode = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    imul_unit #(.XLEN(XLEN), .TAG_W(TAG_W), .MUL_CYCLES(MUL_CYCLES)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_sel   (req_sel),
        .req_word  (req_word),
        .req_src_a (req_src_a),
        .req_src_b (req_src_b),
        .req_tag   (req_tag),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .rsp_tag   (rsp_tag)
    );

    // Behavioural reference product
    function automatic logic [XLEN-1:0] ref_mul(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                                input logic [2:0] sel, input logic word);
        logic signed [2*XLEN+1:0] ea, eb, p;
        logic signed [63:0] wa, wb, wp;
        if (word) begin
            wa = 64'(signed'(a[31:0]));
            wb = 64'(signed'(b[31:0]));
            wp = wa * wb;
            return {{32{wp[31]}}, wp[31:0]};
        end
        if (sel == 3'd1 || sel == 3'd2) ea = {{(XLEN+2){a[XLEN-1]}}, a};
        else                            ea = {{(XLEN+2){1'b0}}, a};
        if (sel == 3'd1)                eb = {{(XLEN+2){b[XLEN-1]}}, b};
        else                            eb = {{(XLEN+2){1'b0}}, b};
        p = ea * eb;
        if (sel == 3'd1 || sel == 3'd2 || sel == 3'd3) return p[2*XLEN-1:XLEN];
        return p[XLEN-1:0];
    endfunction

    function automatic string req_of(input logic [2:0] sel, input logic word);
        if (word)        return "R6";
        if (sel[2])      return "R5";
        if (sel == 3'd1) return "R2";
        if (sel == 3'd2) return "R3";
        if (sel == 3'd3) return "R4";
        return "R1";
    endfunction

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
        end
    endtask

    // Cycle-level reference timeline
    int               m_st = 0;
    int               m_cnt = 0;
    logic [XLEN-1:0]  m_data = '0;
    logic [TAG_W-1:0] m_tag = '0;
    string            m_rq = "R1";

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (req_valid) begin
                    m_data = ref_mul(req_src_a, req_src_b, req_sel, req_word);
                    m_tag  = req_tag;
                    m_rq   = req_of(req_sel, req_word);
                    m_cnt  = 0;
                    m_st   = 1;
                end
                1: if (m_cnt == MUL_CYCLES - 1) m_st = 2; else m_cnt++;
                2: if (rsp_ready) m_st = 0;
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            check(req_ready == 1'b1, "R10", 64'(req_ready), 64'd1);
            check(rsp_valid == 1'b0, "R10", 64'(rsp_valid), 64'd0);
        end else if (!done) begin
            check(req_ready == (m_st == 0), "R7", 64'(req_ready), 64'(m_st == 0));
            check(rsp_valid == (m_st == 2), "R8", 64'(rsp_valid), 64'(m_st == 2));
            if (m_st == 2) begin
                check(rsp_data == m_data, m_rq, rsp_data, m_data);
                check(rsp_tag == m_tag, "R9", 64'(rsp_tag), 64'(m_tag));
            end
        end
    end

    // Response-side back-pressure
    initial begin
        forever begin
            @(negedge clk);
            rsp_ready = stall_mode ? (($urandom % 4) == 0) : 1'b1;
        end
    end

    task automatic issue(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         input logic [2:0] sel, input logic word, input logic [TAG_W-1:0] tag);
        req_valid = 1'b1;
        req_src_a = a;
        req_src_b = b;
        req_sel   = sel;
        req_word  = word;
        req_tag   = tag;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_src_a = ~a;
        req_sel   = ~sel;
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        logic [XLEN-1:0] corners [4];
        logic [TAG_W-1:0] t;
        corners[0] = '0;
        corners[1] = '1;
        corners[2] = {1'b1, {(XLEN-1){1'b0}}};
        corners[3] = {1'b0, {(XLEN-1){1'b1}}};
        t = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Corner operands over every code and both modes (R1-style tags in messages)
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 8; s++) begin
                for (int i = 0; i < 4; i++) begin
                    for (int j = 0; j < 4; j++) begin
                        issue(corners[i], corners[j], 3'(s), w[0], t);
                        t = t + 1'b1;
                    end
                end
            end
        end
        // Random operands with random back-pressure
        stall_mode = 1'b1;
        for (int k = 0; k < 300; k++) begin
            issue({$urandom, $urandom}, {$urandom, $urandom}, 3'($urandom % 8),
                  (($urandom % 4) == 0), t);
            t = t + 1'b1;
        end
        stall_mode = 1'b0;
        repeat (MUL_CYCLES + 4) @(negedge clk);
        done = 1'b1;
        report();
    end

    initial begin
        wait (cycles > WATCHDOG);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        report();
    end

endmodule